// File: doc/BRIEF.md
# Cache-Hint Instruction Decoder

This block looks at a 32-bit instruction word and decides whether it is one of the cache-block maintenance operations, the block-zero operation, or one of the three prefetch hints. None of these has an encoding space of its own. The prefetch hints sit inside the immediate-OR encodings with a zero destination register. The block operations sit inside the 128-bit load encodings with a zero destination register and a zero upper field. Where a word fits one of these narrow patterns, the pattern wins over the broad base instruction. Where it does not fit, the base instruction is reported.

Three enable inputs turn the management group (invalidate, clean, flush), the zero operation and the prefetch group on or off. A disabled group never claims a word, so that word decodes as the base instruction it overlaps. The result is registered once: a one-hot operation class, the rs1 index and the signed prefetch offset are due at the first rising clock edge after the word is presented.

Top module: `cbo_hint_decoder`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces op_o to the other class (bit 9 only), rs1_o to 0 and pref_off_o to 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge; it holds until the next edge.
- R3: With prefetch enabled, opcode 0010011, funct3 (bits 14:12) 110, rd (bits 11:7) zero and bits 24:20 of 00000, 00001 or 00011 give op_o bit 0, bit 1 or bit 2 (instruction, read, write prefetch).
- R4: For a decoded prefetch, pref_off_o carries bits 31:25 as a signed 7-bit value; for every other class it is zero.
- R5: A word with opcode 0010011 and funct3 110 that is not a decoded prefetch gives op_o bit 7 (immediate OR).
- R6: Opcode 0001111, funct3 010, rd zero, bits 31:25 zero and bits 24:20 of 00000, 00001, 00010 or 00100 give op_o bit 3 (invalidate), bit 4 (clean), bit 5 (flush) or bit 6 (zero) when the owning group is enabled.
- R7: A word with opcode 0001111 and funct3 010 that is not a decoded block operation gives op_o bit 8 (128-bit load).
- R8: With the management enable low, invalidate, clean and flush patterns decode as the 128-bit load; with the zero enable low, the zero pattern does. Each enable affects only its own group.
- R9: With the prefetch enable low, every prefetch pattern decodes as the immediate OR with offset zero.
- R10: Any word outside both opcode/funct3 spaces gives op_o bit 9; rs1_o is always bits 19:15 of the word.
- R11: Exactly one bit of op_o is set at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word to classify |
| en_mgmt_i | input | 1 | Enables invalidate, clean and flush decode |
| en_zero_i | input | 1 | Enables block-zero decode |
| en_pref_i | input | 1 | Enables prefetch decode |
| op_o | output | 10 | One-hot class: 0 pf-instr, 1 pf-read, 2 pf-write, 3 inval, 4 clean, 5 flush, 6 zero, 7 OR-imm, 8 load-128, 9 other |
| rs1_o | output | 5 | Base register index, bits 19:15 |
| pref_off_o | output | 7 | Signed prefetch offset, bits 31:25, zero unless a prefetch |

## Verification
All three results share one register stage, so each is due at the first rising edge after the word and enables are applied, and none changes before it. The bench applies a new word at a falling edge and reads the outputs one nanosecond after the following rising edge, so each reading belongs to exactly one stimulus. A separate latency test reads the outputs just after a new word is applied and again after the edge, confirming the old result still holds before the edge and the new one after it; the reset tests read during reset, with the asynchronous clear taking effect without an edge.

// File: rtl/cbo_dec_pkg.sv
package cbo_dec_pkg;

    localparam int ILEN   = 32;
    localparam int OPC_W  = 7;
    localparam int F3_W   = 3;
    localparam int RIDX_W = 5;
    localparam int SEL_W  = 5;
    localparam int OFF_W  = 7;

    // one-hot positions of the operation class
    localparam int OPI_PF_I  = 0;
    localparam int OPI_PF_R  = 1;
    localparam int OPI_PF_W  = 2;
    localparam int OPI_INVAL = 3;
    localparam int OPI_CLEAN = 4;
    localparam int OPI_FLUSH = 5;
    localparam int OPI_ZERO  = 6;
    localparam int OPI_ORI   = 7;
    localparam int OPI_LQ    = 8;
    localparam int OPI_OTHER = 9;
    localparam int OP_W      = OPI_OTHER + 1;

    localparam int N_PF = OPI_PF_W - OPI_PF_I + 1;
    localparam int N_CB = OPI_ZERO - OPI_INVAL + 1;

    localparam logic [OPC_W-1:0] OPC_OPIMM = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_MISC  = 7'b0001111;
    localparam logic [F3_W-1:0]  F3_ORI    = 3'b110;
    localparam logic [F3_W-1:0]  F3_LQ     = 3'b010;

    // selector codes in bits 24:20, listed in one-hot order
    localparam logic [SEL_W-1:0] PF_SEL [N_PF] = '{5'b00000, 5'b00001, 5'b00011};
    localparam logic [SEL_W-1:0] CB_SEL [N_CB] = '{5'b00000, 5'b00001, 5'b00010, 5'b00100};

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [RIDX_W-1:0] rs1;
        logic [OFF_W-1:0]  off;
    } dec_t;

    localparam dec_t DEC_RST = '{op: OP_W'(1) << OPI_OTHER, rs1: '0, off: '0};

endpackage

// File: rtl/cbo_hint_match.sv
module cbo_hint_match
    import cbo_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    input  logic [F3_W-1:0]  f3_i,
    input  logic [4:0]       rd_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_i,
    output logic             space_o,
    output logic [N_PF-1:0]  hit_o
);

    logic shape_ok;

    assign space_o  = (opc_i == OPC_OPIMM) && (f3_i == F3_ORI);
    assign shape_ok = space_o && (rd_i == '0) && en_i;

    for (genvar g = 0; g < N_PF; g++) begin : g_pf
        assign hit_o[g] = shape_ok && (sel_i == PF_SEL[g]);
    end

endmodule

// File: rtl/cbo_blk_match.sv
module cbo_blk_match
    import cbo_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    input  logic [F3_W-1:0]  f3_i,
    input  logic [4:0]       rd_i,
    input  logic [6:0]       f7_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_CB-1:0]  en_i,
    output logic             space_o,
    output logic [N_CB-1:0]  hit_o
);

    logic shape_ok;

    assign space_o  = (opc_i == OPC_MISC) && (f3_i == F3_LQ);
    assign shape_ok = space_o && (rd_i == '0) && (f7_i == '0);

    for (genvar g = 0; g < N_CB; g++) begin : g_cb
        assign hit_o[g] = shape_ok && en_i[g] && (sel_i == CB_SEL[g]);
    end

endmodule

// File: rtl/cbo_hint_decoder.sv
module cbo_hint_decoder
    import cbo_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ILEN-1:0]   insn_i,
    input  logic              en_mgmt_i,
    input  logic              en_zero_i,
    input  logic              en_pref_i,
    output logic [OP_W-1:0]   op_o,
    output logic [RIDX_W-1:0] rs1_o,
    output logic [OFF_W-1:0]  pref_off_o
);

    logic             ori_space;
    logic             lq_space;
    logic [N_PF-1:0]  pf_hit;
    logic [N_CB-1:0]  cb_hit;
    logic [N_CB-1:0]  cb_en;
    dec_t             dec_d;
    dec_t             dec_q;

    // invalidate, clean, flush belong to management; last slot is zero
    assign cb_en = {en_zero_i, {(N_CB-1){en_mgmt_i}}};

    cbo_hint_match u_hint (
        .opc_i   (insn_i[6:0]),
        .f3_i    (insn_i[14:12]),
        .rd_i    (insn_i[11:7]),
        .sel_i   (insn_i[24:20]),
        .en_i    (en_pref_i),
        .space_o (ori_space),
        .hit_o   (pf_hit)
    );

    cbo_blk_match u_blk (
        .opc_i   (insn_i[6:0]),
        .f3_i    (insn_i[14:12]),
        .rd_i    (insn_i[11:7]),
        .f7_i    (insn_i[31:25]),
        .sel_i   (insn_i[24:20]),
        .en_i    (cb_en),
        .space_o (lq_space),
        .hit_o   (cb_hit)
    );

    // narrow patterns first, then the base instruction of each space
    always_comb begin
        dec_d     = '0;
        dec_d.rs1 = insn_i[19:15];
        if (|pf_hit) begin
            dec_d.op[OPI_PF_I +: N_PF] = pf_hit;
            dec_d.off                  = insn_i[31:25];
        end else if (ori_space) begin
            dec_d.op[OPI_ORI] = 1'b1;
        end else if (|cb_hit) begin
            dec_d.op[OPI_INVAL +: N_CB] = cb_hit;
        end else if (lq_space) begin
            dec_d.op[OPI_LQ] = 1'b1;
        end else begin
            dec_d.op[OPI_OTHER] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= DEC_RST;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign op_o       = dec_q.op;
    assign rs1_o      = dec_q.rs1;
    assign pref_off_o = dec_q.off;

endmodule

// File: rtl/cbo_dec_chk.sv
module cbo_dec_chk
    import cbo_dec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ILEN-1:0]   insn_i,
    input logic              en_mgmt_i,
    input logic              en_zero_i,
    input logic              en_pref_i,
    input logic [OP_W-1:0]   op_o,
    input logic [RIDX_W-1:0] rs1_o,
    input logic [OFF_W-1:0]  pref_off_o
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(op_o) == 1); // R11

    AST_RS1_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> rs1_o == $past(insn_i[19:15])); // R10

    AST_OFF_ONLY_PF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o[OPI_PF_W:OPI_PF_I] == '0) |-> pref_off_o == '0); // R4

    AST_PF_OFF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && op_o[OPI_PF_W:OPI_PF_I] != '0) |-> pref_off_o == $past(insn_i[31:25])); // R4

    AST_PF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(en_pref_i)) |-> op_o[OPI_PF_W:OPI_PF_I] == '0); // R9

    AST_MGMT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(en_mgmt_i)) |-> op_o[OPI_FLUSH:OPI_INVAL] == '0); // R8

    AST_ZERO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(en_zero_i)) |-> !op_o[OPI_ZERO]); // R8

    AST_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q
         && !($past(insn_i[6:0]) == OPC_OPIMM && $past(insn_i[14:12]) == F3_ORI)
         && !($past(insn_i[6:0]) == OPC_MISC  && $past(insn_i[14:12]) == F3_LQ))
        |-> op_o[OPI_OTHER]); // R10

endmodule

bind cbo_hint_decoder cbo_dec_chk chk_i (.*);

// File: tb/cbo_hint_decoder_tb_top.sv
module cbo_hint_decoder_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [9:0] PFI = 10'h001, PFR = 10'h002, PFW = 10'h004;
    localparam logic [9:0] INV = 10'h008, CLN = 10'h010, FLS = 10'h020;
    localparam logic [9:0] ZER = 10'h040, ORI = 10'h080, LQ  = 10'h100;
    localparam logic [9:0] OTH = 10'h200;

    typedef struct packed {
        logic [31:0] insn;
        logic [2:0]  en;   // {mgmt, zero, pref}
        logic [9:0]  op;
        logic [6:0]  off;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        // R3 R4: prefetch patterns with offsets
        '{{7'h05, 5'b00000, 5'd3,  3'b110, 5'd0, 7'b0010011}, 3'b111, PFI, 7'h05},
        '{{7'h40, 5'b00001, 5'd31, 3'b110, 5'd0, 7'b0010011}, 3'b111, PFR, 7'h40},
        '{{7'h7f, 5'b00011, 5'd0,  3'b110, 5'd0, 7'b0010011}, 3'b111, PFW, 7'h7f},
        // R5: not a prefetch pattern
        '{{7'h11, 5'b00010, 5'd4,  3'b110, 5'd0, 7'b0010011}, 3'b111, ORI, 7'h00},
        '{{7'h22, 5'b00000, 5'd5,  3'b110, 5'd1, 7'b0010011}, 3'b111, ORI, 7'h00},
        // R6: block operations
        '{{7'h00, 5'b00000, 5'd10, 3'b010, 5'd0, 7'b0001111}, 3'b111, INV, 7'h00},
        '{{7'h00, 5'b00001, 5'd11, 3'b010, 5'd0, 7'b0001111}, 3'b111, CLN, 7'h00},
        '{{7'h00, 5'b00010, 5'd12, 3'b010, 5'd0, 7'b0001111}, 3'b111, FLS, 7'h00},
        '{{7'h00, 5'b00100, 5'd13, 3'b010, 5'd0, 7'b0001111}, 3'b111, ZER, 7'h00},
        // R7: not a block-operation pattern
        '{{7'h00, 5'b00011, 5'd14, 3'b010, 5'd0, 7'b0001111}, 3'b111, LQ,  7'h00},
        '{{7'h01, 5'b00000, 5'd15, 3'b010, 5'd0, 7'b0001111}, 3'b111, LQ,  7'h00},
        '{{7'h00, 5'b00001, 5'd16, 3'b010, 5'd2, 7'b0001111}, 3'b111, LQ,  7'h00},
        // R8: per-group enables
        '{{7'h00, 5'b00001, 5'd17, 3'b010, 5'd0, 7'b0001111}, 3'b011, LQ,  7'h00},
        '{{7'h00, 5'b00100, 5'd18, 3'b010, 5'd0, 7'b0001111}, 3'b011, ZER, 7'h00},
        '{{7'h00, 5'b00100, 5'd19, 3'b010, 5'd0, 7'b0001111}, 3'b101, LQ,  7'h00},
        '{{7'h00, 5'b00000, 5'd20, 3'b010, 5'd0, 7'b0001111}, 3'b101, INV, 7'h00},
        // R9: prefetch disabled
        '{{7'h33, 5'b00001, 5'd21, 3'b110, 5'd0, 7'b0010011}, 3'b110, ORI, 7'h00},
        // R10: outside both spaces
        '{{7'h00, 5'b00000, 5'd22, 3'b000, 5'd3, 7'b0110011}, 3'b111, OTH, 7'h00},
        '{{7'h00, 5'b00000, 5'd23, 3'b000, 5'd0, 7'b0010011}, 3'b111, OTH, 7'h00},
        '{{7'h00, 5'b00000, 5'd24, 3'b000, 5'd0, 7'b0001111}, 3'b111, OTH, 7'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;
    logic        en_mgmt = 1'b1, en_zero = 1'b1, en_pref = 1'b1;
    logic [9:0]  op;
    logic [4:0]  rs1;
    logic [6:0]  off;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    cbo_hint_decoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_i     (insn),
        .en_mgmt_i  (en_mgmt),
        .en_zero_i  (en_zero),
        .en_pref_i  (en_pref),
        .op_o       (op),
        .rs1_o      (rs1),
        .pref_off_o (off)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [2:0] e);
        @(negedge clk);
        insn = w;
        {en_mgmt, en_zero, en_pref} = e;
    endtask

    initial begin
        // R1: reset state while a prefetch word is present
        insn = {7'h15, 5'b00001, 5'd9, 3'b110, 5'd0, 7'b0010011};
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset op", 32'(op), 32'(OTH));
        chk("R1 reset rs1", 32'(rs1), 32'd0);
        chk("R1 reset off", 32'(off), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].insn, VEC[i].en);
            @(posedge clk);
            #1;
            chk($sformatf("vector %0d op (R3..R10 table)", i), 32'(op), 32'(VEC[i].op));
            chk($sformatf("R10 vector %0d rs1", i), 32'(rs1), 32'(VEC[i].insn[19:15]));
            chk($sformatf("R4 vector %0d off", i), 32'(off), 32'(VEC[i].off));
            chk($sformatf("R11 vector %0d one-hot", i), 32'($countones(op)), 32'd1);
        end

        // R2: old result holds until the edge, new one follows it
        apply({7'h6a, 5'b00011, 5'd7, 3'b110, 5'd0, 7'b0010011}, 3'b111);
        #1;
        chk("R2 before edge op", 32'(op), 32'(OTH));
        chk("R2 before edge rs1", 32'(rs1), 32'd24);
        @(posedge clk);
        #1;
        chk("R2 after edge op", 32'(op), 32'(PFW));
        chk("R2 after edge off", 32'(off), 32'h6a);

        // R9: same word with prefetch disabled, offset cleared
        apply({7'h6a, 5'b00011, 5'd7, 3'b110, 5'd0, 7'b0010011}, 3'b110);
        @(posedge clk);
        #1;
        chk("R9 disabled op", 32'(op), 32'(ORI));
        chk("R9 disabled off", 32'(off), 32'd0);

        // R8: all groups off, flush falls to the load
        apply({7'h00, 5'b00010, 5'd8, 3'b010, 5'd0, 7'b0001111}, 3'b000);
        @(posedge clk);
        #1;
        chk("R8 all off flush", 32'(op), 32'(LQ));

        // R1: asynchronous reset mid-run, no edge needed
        apply({7'h01, 5'b00000, 5'd6, 3'b110, 5'd0, 7'b0010011}, 3'b111);
        @(posedge clk);
        #1;
        chk("R3 before reset", 32'(op), 32'(PFI));
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 async op", 32'(op), 32'(OTH));
        chk("R1 async rs1", 32'(rs1), 32'd0);
        chk("R1 async off", 32'(off), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R3 after reset", 32'(op), 32'(PFI));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule